// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the interrupt causes of a single-channel UART and drives one active-low interrupt request. The causes are the receiver and transmitter interrupt levels, a break-edge pulse from the receiver, zero-count events from the counter/timer, and changes on four general input pins. The level causes are passed through live. The event causes are held in sticky flags, and each flag has its own clear rule: a register read, a command strobe, or none at all.

A CPU reaches the block over a small register bus. The bus has an address, a read strobe, a write strobe and byte-wide data. One address returns the true unmasked status on reads and loads the enable mask on writes. A second address returns the pin-change register and clears it. A third address holds a byte that serves either as the interrupt vector or as general-purpose storage. While the acknowledge input is low, that byte is driven onto the read bus.

The counter-ready flag works in two ways. In counter mode it sets on every terminal-count event. In timer mode it sets on every second zero event, which marks one full square-wave period. A stop command clears the flag in both modes. It does not restart the timer's period phase.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset, the status read at address 0x5 returns 0x00, the vector read at 0xC returns 0x0F, the mask is 0x00, irqN is high and rdData is 0x00 while no read is in progress.
- R2: Status bit 1 equals rxIrq and bit 0 equals txIrq in the same cycle, with no latching. A status read returns the unmasked value whatever the mask holds. Status bits 6:4 always read 0.
- R3: A write to 0x5 loads the mask, with bits 6:4 forced to 0, from the next cycle on. irqN is low exactly when some status bit and the matching mask bit are both 1.
- R4: A breakEdge pulse sets status bit 2, which then holds until a rstBreakCmd pulse. If both arrive in the same cycle, the bit is set.
- R5: When timerMode is 0, every cntZero pulse sets status bit 3, and a stopCntCmd pulse clears it. If both arrive in the same cycle, the bit is set.
- R6: When timerMode is 1, status bit 3 sets on every second cntZero pulse. A stopCntCmd pulse clears the bit but leaves the pulse phase unchanged.
- R7: Each input pin passes through a two-stage synchronizer. A level change on a pin whose chgEnable bit is 1 sets status bit 7 on the third rising edge after the pin changes. A change on a pin whose chgEnable bit is 0 leaves bit 7 at 0.
- R8: A read of 0x4 returns the latched change flags in bits 7:4 (pin n in bit 4+n) and the synchronized pin levels in bits 3:0. The read clears the change flags and status bit 7 at the end of the read cycle. Changes are latched whatever chgEnable holds.
- R9: The byte at 0xC is read and written over the bus. While iackN is low, rdData shows that byte even when no read strobe is active.
- R10: A read of any address other than 0x4, 0x5 or 0xC returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register address |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| iackN | input | 1 | Interrupt acknowledge, active low |
| rxIrq | input | 1 | Receiver interrupt level |
| txIrq | input | 1 | Transmitter interrupt level |
| breakEdge | input | 1 | Pulse at the start or end of a received break |
| cntZero | input | 1 | Pulse on counter terminal count or timer zero |
| timerMode | input | 1 | 1 selects timer mode, 0 selects counter mode |
| stopCntCmd | input | 1 | Stop-counter command pulse |
| rstBreakCmd | input | 1 | Reset-break-change command pulse |
| inPins | input | 4 | Asynchronous input pins |
| chgEnable | input | 4 | Per-pin change interrupt enable |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The live bits (Rx, Tx) and the acknowledge drive of the vector are due in the same cycle, so the bench samples them one nanosecond after it changes the inputs on a falling edge. Mask writes, command strobes, break pulses and counter events are due after one rising edge. The bench drives each of them for one clock and samples at the next falling edge. A pin change is due three rising edges later: two synchronizer stages and one flag register. The bench checks irqN after two edges, where it must still be high, and again after three edges. The clear that a change-register read causes shows up only at the following read, so the bench checks it with a second read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef struct packed {
    logic wrMask;
    logic wrVec;
    logic rdChg;
    logic stopCnt;
    logic rstBrk;
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_CHG    = 2'd2,
    RD_VEC    = 2'd3
  } rdSel_e;

  localparam int unsigned DATA_W = 8;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 'h5,
  parameter logic [ADDR_W-1:0] ADDR_CHG  = 'h4,
  parameter logic [ADDR_W-1:0] ADDR_VEC  = 'hC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              iackN,
  input  logic              stopCntCmd,
  input  logic              rstBreakCmd,
  output ctrlStrb_t         strb,
  output rdSel_e            rdSel
);

  always_comb begin
    strb.wrMask  = wrStb && (addr == ADDR_STAT);
    strb.wrVec   = wrStb && (addr == ADDR_VEC);
    strb.rdChg   = rdStb && iackN && (addr == ADDR_CHG);
    strb.stopCnt = stopCntCmd;
    strb.rstBrk  = rstBreakCmd;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (!iackN) begin
      rdSel = RD_VEC;
    end else if (rdStb) begin
      if (addr == ADDR_STAT)     rdSel = RD_STATUS;
      else if (addr == ADDR_CHG) rdSel = RD_CHG;
      else if (addr == ADDR_VEC) rdSel = RD_VEC;
    end
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxIrq,
  input  logic              txIrq,
  input  logic              breakEdge,
  input  logic              cntZero,
  input  logic              timerMode,
  input  logic [NPINS-1:0]  inPins,
  input  logic [NPINS-1:0]  chgEnable,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusVal,
  output logic [DATA_W-1:0] maskVal,
  output logic              irqN
);

  localparam logic [DATA_W-1:0] MASK_USED = 8'b1000_1111;

  logic [NPINS-1:0] syncQ [SYNC_STAGES];
  logic [NPINS-1:0] syncOut, pinPrevQ, pinEdge, deltaQ;
  logic             chgFlagQ, brkQ, cntFlagQ, phaseQ, cntEvt;
  logic [DATA_W-1:0] maskQ, vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= inPins;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign pinEdge = syncOut ^ pinPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrevQ <= '0;
      deltaQ   <= '0;
      chgFlagQ <= 1'b0;
    end else begin
      pinPrevQ <= syncOut;
      deltaQ   <= (strb.rdChg ? '0 : deltaQ) | pinEdge;
      if (|(pinEdge & chgEnable)) chgFlagQ <= 1'b1;
      else if (strb.rdChg)        chgFlagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            brkQ <= 1'b0;
    else if (breakEdge)   brkQ <= 1'b1;
    else if (strb.rstBrk) brkQ <= 1'b0;
  end

  assign cntEvt = cntZero && (!timerMode || phaseQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= 1'b0;
      cntFlagQ <= 1'b0;
    end else begin
      phaseQ <= timerMode ? (phaseQ ^ cntZero) : 1'b0;
      if (cntEvt)            cntFlagQ <= 1'b1;
      else if (strb.stopCnt) cntFlagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      vecQ  <= VEC_RESET;
    end else begin
      if (strb.wrMask) maskQ <= wrData & MASK_USED;
      if (strb.wrVec)  vecQ  <= wrData;
    end
  end

  assign statusVal = {chgFlagQ, 3'b000, cntFlagQ, brkQ, rxIrq, txIrq};
  assign maskVal   = maskQ;
  assign irqN      = ~|(statusVal & maskQ);

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdData = statusVal;
      RD_CHG:    rdData = {deltaQ, syncOut};
      RD_VEC:    rdData = vecQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned NPINS       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              iackN,
  input  logic              rxIrq,
  input  logic              txIrq,
  input  logic              breakEdge,
  input  logic              cntZero,
  input  logic              timerMode,
  input  logic              stopCntCmd,
  input  logic              rstBreakCmd,
  input  logic [NPINS-1:0]  inPins,
  input  logic [NPINS-1:0]  chgEnable,
  output logic              irqN
);

  ctrlStrb_t   strb;
  rdSel_e      rdSel;
  logic [7:0]  statusVal, maskVal;

  uart_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .addr(addr), .rdStb(rdStb), .wrStb(wrStb), .iackN(iackN),
    .stopCntCmd(stopCntCmd), .rstBreakCmd(rstBreakCmd),
    .strb(strb), .rdSel(rdSel)
  );

  uart_irq_datapath #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wrData(wrData),
    .rxIrq(rxIrq), .txIrq(txIrq), .breakEdge(breakEdge), .cntZero(cntZero),
    .timerMode(timerMode), .inPins(inPins), .chgEnable(chgEnable),
    .rdData(rdData), .statusVal(statusVal), .maskVal(maskVal), .irqN(irqN)
  );

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdStb,
  input logic              wrStb,
  input logic              iackN,
  input logic [7:0]        rdData,
  input logic              rxIrq,
  input logic              txIrq,
  input logic              breakEdge,
  input logic              cntZero,
  input logic              timerMode,
  input logic              stopCntCmd,
  input logic              rstBreakCmd,
  input logic [7:0]        statusVal,
  input logic [7:0]        maskVal,
  input logic              irqN
);

  // R2
  status_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && iackN && addr == 'h5) |-> (rdData[6:4] == 3'b000 && rdData[1:0] == {rxIrq, txIrq}));

  // R3
  mask_resv_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskVal[6:4] == 3'b000);

  // R3
  no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskVal == 8'h00) |-> irqN);

  // R4
  brk_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakEdge |=> statusVal[2]);

  // R4
  brk_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstBreakCmd && !breakEdge) |=> !statusVal[2]);

  // R5
  cnt_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopCntCmd && !cntZero) |=> !statusVal[3]);

  // R5
  cnt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !timerMode) |=> statusVal[3]);

  // R9
  iack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!iackN && $past(!iackN) && $past(rstN) && !$past(wrStb)) |-> $stable(rdData));

endmodule

bind uart_irq_unit uart_irq_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
  .iackN(iackN), .rdData(rdData), .rxIrq(rxIrq), .txIrq(txIrq),
  .breakEdge(breakEdge), .cntZero(cntZero), .timerMode(timerMode),
  .stopCntCmd(stopCntCmd), .rstBreakCmd(rstBreakCmd),
  .statusVal(statusVal), .maskVal(maskVal), .irqN(irqN)
);

// File: tb/uart_irq_unit_tb_top.sv
`timescale 1ns/100ps
module uart_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic       rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       iackN = 1'b1;
  logic       rxIrq = 1'b0, txIrq = 1'b0, breakEdge = 1'b0, cntZero = 1'b0;
  logic       timerMode = 1'b0, stopCntCmd = 1'b0, rstBreakCmd = 1'b0;
  logic [3:0] inPins = '0, chgEnable = '0;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .iackN(iackN), .rxIrq(rxIrq),
    .txIrq(txIrq), .breakEdge(breakEdge), .cntZero(cntZero),
    .timerMode(timerMode), .stopCntCmd(stopCntCmd), .rstBreakCmd(rstBreakCmd),
    .inPins(inPins), .chgEnable(chgEnable), .irqN(irqN)
  );

  // {mask[7:0], rx, tx, expected irqN}
  localparam logic [10:0] VECS [6] = '{
    {8'h00, 1'b1, 1'b1, 1'b1},
    {8'h01, 1'b0, 1'b1, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b1},
    {8'h02, 1'b1, 1'b0, 1'b0},
    {8'h03, 1'b0, 1'b0, 1'b1},
    {8'hF0, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rdStb = 1'b1;
    #1 d = rdData;
    tick();
    rdStb = 1'b0;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrStb = 1'b1;
    tick();
    wrStb = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(2);
    rstN = 1'b1;
    tick();

    // R1 reset state
    check("R1 idle rdData", rdData, 8'h00);
    check("R1 irqN", {7'b0, irqN}, 8'h01);
    readReg(4'h5, d); check("R1 status", d, 8'h00);
    readReg(4'hC, d); check("R1 vector", d, 8'h0F);

    // R2 R3 table walk
    foreach (VECS[i]) begin
      writeReg(4'h5, VECS[i][10:3]);
      rxIrq = VECS[i][2]; txIrq = VECS[i][1];
      #1 check("R3 irqN table", {7'b0, irqN}, {7'b0, VECS[i][0]});
      readReg(4'h5, d);
      check("R2 status table", d, {6'b0, VECS[i][2], VECS[i][1]});
    end
    rxIrq = 1'b0; txIrq = 1'b0;

    // R4 break flag
    writeReg(4'h5, 8'h04);
    breakEdge = 1'b1; tick(); breakEdge = 1'b0;
    check("R4 break irqN", {7'b0, irqN}, 8'h00);
    readReg(4'h5, d); check("R4 break set", d, 8'h04);
    breakEdge = 1'b1; rstBreakCmd = 1'b1; tick();
    breakEdge = 1'b0; rstBreakCmd = 1'b0;
    readReg(4'h5, d); check("R4 set wins", d, 8'h04);
    rstBreakCmd = 1'b1; tick(); rstBreakCmd = 1'b0;
    readReg(4'h5, d); check("R4 cleared", d, 8'h00);
    check("R4 irqN released", {7'b0, irqN}, 8'h01);

    // R5 counter mode
    cntZero = 1'b1; tick(); cntZero = 1'b0;
    readReg(4'h5, d); check("R5 counter set", d, 8'h08);
    stopCntCmd = 1'b1; tick(); stopCntCmd = 1'b0;
    readReg(4'h5, d); check("R5 stop clears", d, 8'h00);

    // R6 timer mode
    timerMode = 1'b1;
    cntZero = 1'b1; tick(); cntZero = 1'b0;
    readReg(4'h5, d); check("R6 first zero", d, 8'h00);
    cntZero = 1'b1; tick(); cntZero = 1'b0;
    readReg(4'h5, d); check("R6 second zero", d, 8'h08);
    stopCntCmd = 1'b1; tick(); stopCntCmd = 1'b0;
    readReg(4'h5, d); check("R6 stop clears", d, 8'h00);
    cntZero = 1'b1; tick(); cntZero = 1'b0;
    readReg(4'h5, d); check("R6 third zero", d, 8'h00);
    cntZero = 1'b1; tick(); cntZero = 1'b0;
    readReg(4'h5, d); check("R6 fourth zero", d, 8'h08);
    stopCntCmd = 1'b1; tick(); stopCntCmd = 1'b0;
    timerMode = 1'b0;

    // R7 R8 input pins
    writeReg(4'h5, 8'h80);
    chgEnable = 4'b0001;
    inPins[0] = 1'b1;
    tick(2);
    check("R7 not yet", {7'b0, irqN}, 8'h01);
    tick();
    check("R7 irq after 3 edges", {7'b0, irqN}, 8'h00);
    readReg(4'h5, d); check("R7 status bit7", d, 8'h80);
    readReg(4'h4, d); check("R8 change reg", d, 8'h11);
    readReg(4'h4, d); check("R8 change cleared", d, 8'h01);
    readReg(4'h5, d); check("R8 bit7 cleared", d, 8'h00);
    inPins[1] = 1'b1;
    tick(4);
    check("R7 disabled pin irqN", {7'b0, irqN}, 8'h01);
    readReg(4'h5, d); check("R7 disabled pin status", d, 8'h00);
    readReg(4'h4, d); check("R8 delta latched", d, 8'h23);

    // R9 vector
    writeReg(4'hC, 8'hA5);
    readReg(4'hC, d); check("R9 vector rw", d, 8'hA5);
    iackN = 1'b0;
    #1 check("R9 iack drive", rdData, 8'hA5);
    tick(); iackN = 1'b1;

    // R10 unmapped
    readReg(4'h3, d); check("R10 unmapped", d, 8'h00);
    readReg(4'hF, d); check("R10 unmapped hi", d, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule